// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block holds the mode word of a synchronous DRAM controller and generates the column address of every beat of a read or write burst. A mode-set strobe loads the 12-bit mode word together with the two bank-select bits. The stored word sets the burst length, the address order, the CAS latency and an option that makes every write a single beat. A burst-start strobe carries the first column and a read/write flag. The block then presents one column per clock with a valid flag, and raises a last flag on the final beat.

Bursts can run in sequential or interleaved order. Their length can be 1, 2, 4 or 8 beats, or a full page of 256 columns that runs until a stop strobe ends it. The CAS latency field is decoded and exported so the data path can use it. The block does not use it for timing. An error flag reports a stored mode word that is not legal. A separate one-cycle flag reports a mode-set strobe that was refused because a burst was in progress.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset, col_valid_o, col_last_o, mode_err_o and mode_clash_o are 0. The stored mode is the word 12'h020 (length 1, sequential, latency 2), so cas_lat_o is 2.
- R2: A mode-set strobe that is accepted stores mode_word_i and mode_bank_i at the clock edge. Bursts started after that edge use the new word. cas_lat_o shows bits [6:4] of the stored word decoded as 3'b010 = 2 and 3'b011 = 3; every other code gives 0.
- R3: Bits [2:0] of the word set the burst length: 000 = 1, 001 = 2, 010 = 4, 011 = 8, 111 = full page (256). The reserved codes 100, 101 and 110 run as a single beat.
- R4: In sequential order (bit [3] = 0), the low log2(length) bits of the column count up from the start column modulo the length, and the higher bits keep the start column's value.
- R5: In interleaved order (bit [3] = 1), beat n has low bits equal to the start column's low bits XOR n, and the higher bits keep the start column's value.
- R6: A full-page burst counts up one column per beat from the start column and wraps from 255 to 0. It never raises col_last_o and runs until burst_stop_i. For full page, bit [3] has no effect and the order is always sequential.
- R7: When bit [9] of the stored word is 1, every write burst is one beat long and read bursts use the programmed length.
- R8: mode_err_o is 1 while the stored word breaks any of these rules: bits [8:7] nonzero, bits [11:10] nonzero, bank bits nonzero, a latency code other than 2 or 3, a reserved length code, or interleaved order combined with full page.
- R9: A mode-set strobe in a cycle where col_valid_o is 1, or where burst_start_i is also 1, is refused. The stored word stays unchanged and mode_clash_o is 1 for the following cycle.
- R10: burst_stop_i during an active burst makes col_valid_o 0 from the next cycle. burst_stop_i has no effect when no burst is active.
- R11: The first column appears in the cycle after burst_start_i. col_last_o is 1 on the final beat of a finite burst. burst_start_i during an active burst restarts the burst at the new column, and it wins over a burst_stop_i in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_set_i | input | 1 | Mode-set strobe |
| mode_word_i | input | 12 | Mode word, bits [11:0] |
| mode_bank_i | input | 2 | Bank-select bits seen with the mode set; must be zero |
| burst_start_i | input | 1 | Starts a burst |
| burst_col_i | input | 8 | First column of the burst |
| burst_write_i | input | 1 | 1 = write burst, 0 = read burst |
| burst_stop_i | input | 1 | Ends the active burst early |
| col_o | output | 8 | Column of the current beat |
| col_valid_o | output | 1 | col_o holds a beat |
| col_last_o | output | 1 | Final beat of a finite burst |
| cas_lat_o | output | 2 | Decoded CAS latency (2, 3, or 0 when reserved) |
| mode_err_o | output | 1 | Stored mode word is illegal |
| mode_clash_o | output | 1 | Mode set refused in the previous cycle |

## Verification
The assertions check the rules that hold on every cycle. Each beat stays inside the aligned block of the start column. A stop or a last beat ends the burst on the next edge unless a new start arrives. A full-page burst never raises the last flag. A refused mode set leaves the stored word unchanged and raises the clash flag, and the decoded latency takes only its three legal values. The bench's scenarios drive the sequences that only a run can show: the exact column order for each length and order, the wrap of a full page, writes reduced to single beats, the error flag for each illegal field, and restarts during a burst.

// File: rtl/colgen_pkg.sv
package colgen_pkg;
  localparam int MODE_W = 12;

  // field positions follow the mode word bit order (MSB first)
  typedef struct packed {
    logic [1:0] rsv_hi;  // [11:10]
    logic       wr_one;  // [9]
    logic [1:0] tmode;   // [8:7]
    logic [2:0] lat;     // [6:4]
    logic       ilv;     // [3]
    logic [2:0] len;     // [2:0]
  } mode_t;

  localparam logic [2:0] LEN_1    = 3'b000;
  localparam logic [2:0] LEN_2    = 3'b001;
  localparam logic [2:0] LEN_4    = 3'b010;
  localparam logic [2:0] LEN_8    = 3'b011;
  localparam logic [2:0] LEN_PAGE = 3'b111;
  localparam logic [2:0] LAT_2    = 3'b010;
  localparam logic [2:0] LAT_3    = 3'b011;

  localparam logic [MODE_W-1:0] MODE_RST = 12'h020;
endpackage

// File: rtl/colgen_mode.sv
module colgen_mode
  import colgen_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       set_i,
  input  mode_t      word_i,
  input  logic [1:0] bank_i,
  input  logic       busy_i,
  output mode_t      mode_o,
  output logic [1:0] cas_lat_o,
  output logic       err_o,
  output logic       clash_o
);
  mode_t      mode_q;
  logic [1:0] bank_q;
  logic       clash_q;
  logic       accept;

  assign accept = set_i && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= mode_t'(MODE_RST);
      bank_q  <= '0;
      clash_q <= 1'b0;
    end else begin
      clash_q <= set_i && busy_i;
      if (accept) begin
        mode_q <= word_i;
        bank_q <= bank_i;
      end
    end
  end

  always_comb begin
    unique case (mode_q.lat)
      LAT_2:   cas_lat_o = 2'd2;
      LAT_3:   cas_lat_o = 2'd3;
      default: cas_lat_o = 2'd0;
    endcase
  end

  logic len_bad;
  always_comb begin
    unique case (mode_q.len)
      LEN_1, LEN_2, LEN_4, LEN_8, LEN_PAGE: len_bad = 1'b0;
      default:                              len_bad = 1'b1;
    endcase
  end

  assign err_o = (mode_q.rsv_hi != '0) || (mode_q.tmode != '0) || (bank_q != '0) ||
                 (cas_lat_o == 2'd0) || len_bad ||
                 (mode_q.ilv && mode_q.len == LEN_PAGE);
  assign mode_o  = mode_q;
  assign clash_o = clash_q;

  // R9
  mode_refuse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i && busy_i |=> $stable(mode_q) && clash_o);

  // R2
  lat_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cas_lat_o != 2'd1);
endmodule

// File: rtl/colgen_seq.sv
module colgen_seq
  import colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  mode_t            mode_i,
  input  logic             start_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             write_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o,
  output logic             busy_o
);
  typedef logic [COL_W-1:0] col_t;

  col_t mask_d, mask_q, st_q, n_q, lo;
  logic full_d, full_q, ilv_d, ilv_q, act_q, at_end;

  // length decode at start time; single-beat writes override the length
  always_comb begin
    full_d = (mode_i.len == LEN_PAGE);
    unique case (mode_i.len)
      LEN_2:    mask_d = col_t'(1);
      LEN_4:    mask_d = col_t'(3);
      LEN_8:    mask_d = col_t'(7);
      LEN_PAGE: mask_d = '1;
      default:  mask_d = '0;
    endcase
    if (write_i && mode_i.wr_one) begin
      mask_d = '0;
      full_d = 1'b0;
    end
    ilv_d = mode_i.ilv && !full_d;
  end

  assign at_end = act_q && !full_q && (n_q == mask_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      n_q    <= '0;
      st_q   <= '0;
      mask_q <= '0;
      full_q <= 1'b0;
      ilv_q  <= 1'b0;
    end else if (start_i) begin
      act_q  <= 1'b1;
      n_q    <= '0;
      st_q   <= col_i;
      mask_q <= mask_d;
      full_q <= full_d;
      ilv_q  <= ilv_d;
    end else if (act_q) begin
      if (stop_i || at_end) act_q <= 1'b0;
      else                  n_q   <= n_q + col_t'(1);
    end
  end

  assign lo      = ilv_q ? (st_q ^ n_q) : (st_q + n_q);
  assign col_o   = (st_q & ~mask_q) | (lo & mask_q);
  assign valid_o = act_q;
  assign last_o  = at_end;
  assign busy_o  = act_q || start_i;

  // R4
  blk_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((col_o ^ st_q) & ~mask_q) == '0);

  // R10
  stop_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && stop_i && !start_i |=> !valid_o);

  // R11
  last_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o && !start_i |=> !valid_o);

  // R11
  run_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !last_o && !stop_i |=> valid_o);

  // R6
  page_no_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_q |-> !last_o);
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_set_i,
  input  logic [MODE_W-1:0] mode_word_i,
  input  logic [1:0]        mode_bank_i,
  input  logic              burst_start_i,
  input  logic [COL_W-1:0]  burst_col_i,
  input  logic              burst_write_i,
  input  logic              burst_stop_i,
  output logic [COL_W-1:0]  col_o,
  output logic              col_valid_o,
  output logic              col_last_o,
  output logic [1:0]        cas_lat_o,
  output logic              mode_err_o,
  output logic              mode_clash_o
);
  mode_t mode;
  logic  busy;

  colgen_mode u_mode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (mode_set_i),
    .word_i    (mode_t'(mode_word_i)),
    .bank_i    (mode_bank_i),
    .busy_i    (busy),
    .mode_o    (mode),
    .cas_lat_o (cas_lat_o),
    .err_o     (mode_err_o),
    .clash_o   (mode_clash_o)
  );

  colgen_seq #(.COL_W(COL_W)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode),
    .start_i (burst_start_i),
    .col_i   (burst_col_i),
    .write_i (burst_write_i),
    .stop_i  (burst_stop_i),
    .col_o   (col_o),
    .valid_o (col_valid_o),
    .last_o  (col_last_o),
    .busy_o  (busy)
  );
endmodule

// File: tb/sim_sdram_burst_colgen.sv
`timescale 1ns/1ps
module sim_sdram_burst_colgen;
  logic clk = 0, rst_ni = 0;
  logic mode_set = 0, b_start = 0, b_wr = 0, b_stop = 0;
  logic [11:0] m_word = 0;
  logic [1:0]  m_bank = 0;
  logic [7:0]  b_col = 0;
  logic [7:0]  col;
  logic        valid, last, clash, merr;
  logic [1:0]  cas;

  always #2.5 clk = ~clk;

  sdram_burst_colgen u0 (
    .clk_i(clk), .rst_ni(rst_ni), .mode_set_i(mode_set), .mode_word_i(m_word),
    .mode_bank_i(m_bank), .burst_start_i(b_start), .burst_col_i(b_col),
    .burst_write_i(b_wr), .burst_stop_i(b_stop), .col_o(col), .col_valid_o(valid),
    .col_last_o(last), .cas_lat_o(cas), .mode_err_o(merr), .mode_clash_o(clash));

  int errors = 0, checks = 0;
  string req = "R1";
  bit done = 0;

  // reference model state
  int m_len, m_ilv, m_lat, m_one, m_err;
  bit e_act, e_clash, e_full, e_ilv;
  int e_st, e_n, e_blk;

  function automatic void load_mode(int w, int bank);
    int lc;
    lc    = w % 8;
    m_ilv = (w / 8) % 2;
    m_lat = (w / 16) % 8;
    m_one = (w / 512) % 2;
    case (lc)
      0: m_len = 1;  1: m_len = 2;  2: m_len = 4;  3: m_len = 8;
      7: m_len = 256;
      default: m_len = 1;
    endcase
    m_err = 0;
    if ((w / 128) % 4 != 0 || w / 1024 != 0 || bank != 0) m_err = 1;
    if (m_lat != 2 && m_lat != 3) m_err = 1;
    if (lc >= 4 && lc <= 6) m_err = 1;
    if (lc == 7 && m_ilv == 1) m_err = 1;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      load_mode(32'h020, 0);
      e_act = 0; e_clash = 0; e_n = 0; e_st = 0; e_blk = 1; e_full = 0; e_ilv = 0;
    end else begin
      bit clash_now;
      clash_now = mode_set && (e_act || b_start);
      if (b_start) begin
        e_act = 1; e_n = 0; e_st = b_col;
        if (b_wr && m_one == 1) begin
          e_blk = 1; e_full = 0; e_ilv = 0;
        end else begin
          e_blk = m_len; e_full = (m_len == 256); e_ilv = (m_ilv == 1) && !e_full;
        end
      end else if (e_act) begin
        if (b_stop) e_act = 0;
        else if (!e_full && e_n == e_blk - 1) e_act = 0;
        else e_n = (e_n + 1) % 256;
      end
      if (mode_set && !clash_now) load_mode(int'(m_word), int'(m_bank));
      e_clash = clash_now;
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      int base, off, ec, el;
      base = e_st - (e_st % e_blk);
      off  = e_st % e_blk;
      ec   = e_ilv ? base + (off ^ e_n) : base + (off + e_n) % e_blk;
      el   = (e_act && !e_full && e_n == e_blk - 1) ? 1 : 0;
      chk("valid", int'(valid), int'(e_act));
      if (e_act) begin
        chk("col", int'(col), ec);
        chk("last", int'(last), el);
      end
      chk("cas_lat", int'(cas), (m_lat == 2) ? 2 : (m_lat == 3) ? 3 : 0);
      chk("mode_err", int'(merr), m_err);
      chk("clash", int'(clash), int'(e_clash));
    end
  end

  task automatic set_mode(input logic [11:0] w, input logic [1:0] bk = 2'b00);
    mode_set = 1; m_word = w; m_bank = bk;
    @(negedge clk);
    mode_set = 0; m_bank = 0;
  endtask

  task automatic burst(input logic [7:0] c, input bit wr, input int gap);
    b_start = 1; b_col = c; b_wr = wr;
    @(negedge clk);
    b_start = 0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic stop_now();
    b_stop = 1;
    @(negedge clk);
    b_stop = 0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      done = 1; errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state seen at the ports
    req = "R1";
    chk("reset valid", int'(valid), 0);
    chk("reset cas", int'(cas), 2);
    chk("reset err", int'(merr), 0);
    rst_ni = 1;
    @(negedge clk);
    req = "R2";  set_mode(12'h032); burst(8'h0D, 0, 5);
    req = "R4";  burst(8'h3A, 0, 5); set_mode(12'h033); burst(8'h5D, 0, 9);
    req = "R5";  set_mode(12'h03B); burst(8'h15, 0, 9); burst(8'hF2, 1, 9);
    set_mode(12'h039); burst(8'h07, 0, 3);
    req = "R3";  set_mode(12'h031); burst(8'h41, 0, 3);
    set_mode(12'h030); burst(8'h99, 0, 3);
    set_mode(12'h034); burst(8'h22, 0, 3);
    set_mode(12'h036); burst(8'h23, 0, 3);
    req = "R6";  set_mode(12'h037); burst(8'hFC, 0, 9); stop_now(); repeat (2) @(negedge clk);
    burst(8'h00, 0, 300); stop_now(); repeat (2) @(negedge clk);
    set_mode(12'h03F); burst(8'hFE, 0, 6); stop_now(); repeat (2) @(negedge clk);
    req = "R7";  set_mode(12'h232); burst(8'h10, 1, 3); burst(8'h10, 0, 5);
    set_mode(12'h233); burst(8'h27, 1, 3);
    req = "R8";  set_mode(12'h432); set_mode(12'h0B2); set_mode(12'h042);
    set_mode(12'h012); set_mode(12'h032, 2'b01); set_mode(12'h802);
    set_mode(12'h022);
    req = "R9";  set_mode(12'h033); burst(8'h30, 0, 2);
    set_mode(12'h030); repeat (6) @(negedge clk);
    mode_set = 1; m_word = 12'h031; b_start = 1; b_col = 8'h44; b_wr = 0;
    @(negedge clk); mode_set = 0; b_start = 0; repeat (9) @(negedge clk);
    req = "R10"; stop_now(); burst(8'h50, 0, 2); stop_now(); repeat (3) @(negedge clk);
    req = "R11"; burst(8'h60, 0, 2); burst(8'h73, 0, 2);
    b_start = 1; b_stop = 1; b_col = 8'h86;
    @(negedge clk); b_start = 0; b_stop = 0; repeat (10) @(negedge clk);
    burst(8'hA1, 0, 7); burst(8'hB0, 0, 0); burst(8'hC5, 0, 9);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule